// File: doc/BRIEF.md
# Programmable Asynchronous Serial Receiver

This block takes characters off one asynchronous serial input line. The frame shape is set at run time: the character length runs from one to eight bits, parity can be off, even or odd, and the frame ends in one or two stop bits. A 16-bit divisor sets the bit rate. Each bit period holds eight sample ticks, and every bit is sampled once, near its centre.

After a character finishes, the block writes it into a one-entry receive buffer and raises a ready flag. It reports parity, framing, overrun and break conditions on separate flags. The interrupt output combines two conditions, ready and break, and one enable gates it. Software empties the buffer with a one-cycle read strobe. A one-cycle clear strobe removes every flag and sends the receiver back to idle.

Top module: `async_rx`

## Requirements
- R1: After reset, all of these are 0: `rx_ready`, `err_parity`, `err_frame`, `err_overrun`, `brk_det`, `rx_irq` and `rx_data`.
- R2: `char_len` = k selects k+1 data bits (k = 0..7). Bits arrive least significant first. `rx_data` holds them right-aligned, and every bit above the character is zero.
- R3: When `par_en` = 1, one parity bit follows the data. `par_even` = 1 selects even parity and 0 selects odd. On a mismatch, `err_parity` is set and the character is still delivered.
- R4: `two_stop` = 1 selects two stop bits and 0 selects one. If any stop bit is sampled as 0, `err_frame` is set and the character is still delivered.
- R5: The start bit is confirmed at the fourth of its eight ticks. A low pulse that has ended by then is discarded, and no character results.
- R6: A character that completes while `rx_ready` is still 1 sets `err_overrun`. That character is dropped, and `rx_data` keeps the earlier one.
- R7: If the line stays low from the start bit through the last stop bit, `brk_det` and `err_frame` are set. In that case `rx_ready` and `rx_data` do not change.
- R8: A one-cycle pulse on `buf_rd` clears `rx_ready` and leaves `rx_data` unchanged.
- R9: A one-cycle pulse on `sw_clr` clears `rx_ready` and all four error flags, and it aborts any frame in progress.
- R10: While `rx_en` = 0, activity on the line sets no flag.
- R11: `rx_irq` is `rx_irq_en` AND (`rx_ready` OR `brk_det`).
- R12: One bit period lasts (`baud_div`+1)×8 clock cycles. Frames sent at this rate are received correctly for any divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_clr | input | 1 | Clears all flags and aborts reception |
| rx_en | input | 1 | Receiver enable |
| rx_irq_en | input | 1 | Interrupt enable |
| baud_div | input | 16 | Divisor; tick every baud_div+1 clocks |
| char_len | input | 3 | Data bits minus one |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| two_stop | input | 1 | 1 = two stop bits |
| rxd | input | 1 | Serial line, idle high |
| buf_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Unread character available |
| err_parity | output | 1 | Parity mismatch seen |
| err_frame | output | 1 | Stop bit sampled low |
| err_overrun | output | 1 | Character lost to overrun |
| brk_det | output | 1 | Break condition seen |
| rx_irq | output | 1 | Interrupt request |

## Verification
A bit-index or tick counter that is off by one shows up within a single frame. The character either comes out shifted or with its top bit wrong, or a parity or framing flag appears on a clean frame. It becomes visible at the ports the moment the stop bit is sampled. A bad state transition has two possible symptoms. A character may be missing after a frame, for example when a glitch was accepted as a start or a real start was thrown away. Or a spurious character may appear a few bit periods after a break. Every frame is therefore checked half a bit period after its final stop sample. Status bookkeeping faults surface on the first read, clear or overlapping character that follows: a missed overrun, a buffer overwritten by a dropped character, or a flag that survives a clear.

// File: rtl/arx_pkg.sv
// Shared types for the asynchronous receiver.
// Assumes: nothing; holds the frame state encoding only.
package arx_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_DATA  = 3'd2,
        S_PAR   = 3'd3,
        S_STOP1 = 3'd4,
        S_STOP2 = 3'd5,
        S_HOLD  = 3'd6
    } arx_state_e;

endpackage

// File: rtl/arx_sync.sv
// Brings the asynchronous serial line into the clock domain.
// Assumes: the line idles high, so every stage resets to 1.
module arx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronising flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/arx_baud.sv
// Produces a one-cycle sample tick every div_i+1 clocks while run_i is high.
// Assumes: the phase restarts from zero whenever run_i drops.
module arx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    // Count clocks up to the divisor and pulse the tick at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt == div_i) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(run_i)) else $error("tick without run"); // R12
endmodule

// File: rtl/arx_deframer.sv
// Walks one frame: confirms the start bit, samples the data, parity and stop bits
// at their centres, and emits a one-cycle done pulse carrying the character and
// per-frame error indications.
// Assumes: line_i is already synchronised; the format inputs are stable during a frame.
module arx_deframer
    import arx_pkg::*;
#(
    parameter int DATA_MAX   = 8,
    parameter int TICKS      = 8,
    parameter int START_TICK = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        en_i,
    input  logic                        line_i,
    input  logic                        tick_i,
    input  logic [$clog2(DATA_MAX)-1:0] len_i,
    input  logic                        pen_i,
    input  logic                        peven_i,
    input  logic                        two_i,
    output logic                        run_o,
    output logic                        done_o,
    output logic [DATA_MAX-1:0]         data_o,
    output logic                        perr_o,
    output logic                        ferr_o,
    output logic                        brk_o
);
    localparam int SUB_W = $clog2(TICKS);
    localparam int IDX_W = $clog2(DATA_MAX);
    localparam logic [SUB_W-1:0] SAMP_FIRST = SUB_W'(START_TICK - 1);
    localparam logic [SUB_W-1:0] SAMP_LAST  = SUB_W'(TICKS - 1);

    arx_state_e          state;
    logic [SUB_W-1:0]    sub;
    logic [IDX_W-1:0]    idx;
    logic [DATA_MAX-1:0] shreg;
    logic                par_acc;
    logic                par_bad;
    logic                all_low;
    logic                stop_bad;
    logic                samp;
    logic                fin;

    // Sample strobe: the fourth tick of the start bit, then every eighth tick.
    always_comb begin
        samp = tick_i && ((state == S_START) ? (sub == SAMP_FIRST) : (sub == SAMP_LAST));
        fin  = samp && ((state == S_STOP1 && !two_i) || state == S_STOP2);
    end

    assign run_o = (state != S_IDLE) && (state != S_HOLD);

    // Frame state machine, data assembly and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || !en_i) begin
            state    <= S_IDLE;
            sub      <= '0;
            idx      <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            par_bad  <= 1'b0;
            all_low  <= 1'b1;
            stop_bad <= 1'b0;
            done_o   <= 1'b0;
            data_o   <= '0;
            perr_o   <= 1'b0;
            ferr_o   <= 1'b0;
            brk_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) sub <= samp ? '0 : sub + 1'b1;
            unique case (state)
                S_IDLE: if (!line_i) begin
                    state    <= S_START;
                    sub      <= '0;
                    idx      <= '0;
                    shreg    <= '0;
                    par_acc  <= 1'b0;
                    par_bad  <= 1'b0;
                    all_low  <= 1'b1;
                    stop_bad <= 1'b0;
                end
                S_START: if (samp) state <= line_i ? S_IDLE : S_DATA;
                S_DATA: if (samp) begin
                    shreg[idx] <= line_i;
                    par_acc    <= par_acc ^ line_i;
                    if (line_i) all_low <= 1'b0;
                    if (idx == len_i) state <= pen_i ? S_PAR : S_STOP1;
                    else              idx   <= idx + 1'b1;
                end
                S_PAR: if (samp) begin
                    par_bad <= par_acc ^ line_i ^ ~peven_i;
                    if (line_i) all_low <= 1'b0;
                    state <= S_STOP1;
                end
                S_STOP1: if (samp && two_i) begin
                    if (line_i) all_low  <= 1'b0;
                    else        stop_bad <= 1'b1;
                    state <= S_STOP2;
                end
                S_STOP2: ;
                S_HOLD: if (line_i) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
            if (fin) begin
                done_o <= 1'b1;
                data_o <= shreg;
                ferr_o <= stop_bad | ~line_i;
                brk_o  <= all_low & ~line_i;
                perr_o <= pen_i & par_bad & ~(all_low & ~line_i);
                state  <= line_i ? S_IDLE : S_HOLD;
            end
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !done_o) else $error("done while disabled"); // R10
    AST_BREAK_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && brk_o) |-> (ferr_o && !perr_o)) else $error("break without framing"); // R7
    AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && samp && line_i && en_i && !clr_i) |=> (state == S_IDLE && !done_o))
        else $error("glitch accepted"); // R5
endmodule

// File: rtl/arx_status.sv
// Holds the receive buffer and the ready, error and break flags; forms the interrupt.
// Assumes: done_i is a single-cycle pulse; a read and a completion never coincide.
module arx_status #(
    parameter int DATA_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                rd_i,
    input  logic                irq_en_i,
    input  logic                done_i,
    input  logic [DATA_MAX-1:0] data_i,
    input  logic                perr_i,
    input  logic                ferr_i,
    input  logic                brk_i,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_overrun,
    output logic                brk_det,
    output logic                rx_irq
);
    // Update the buffer and sticky flags on completion, read and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
            brk_det     <= 1'b0;
        end else if (clr_i) begin
            rx_ready    <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
            brk_det     <= 1'b0;
        end else begin
            if (rd_i) rx_ready <= 1'b0;
            if (done_i) begin
                if (brk_i) begin
                    brk_det   <= 1'b1;
                    err_frame <= 1'b1;
                end else if (rx_ready && !rd_i) begin
                    err_overrun <= 1'b1;
                end else begin
                    rx_data  <= data_i;
                    rx_ready <= 1'b1;
                    if (perr_i) err_parity <= 1'b1;
                    if (ferr_i) err_frame  <= 1'b1;
                end
            end
        end
    end

    assign rx_irq = irq_en_i & (rx_ready | brk_det);

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i && !clr_i) |=> !rx_ready) else $error("read kept ready"); // R8
    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !brk_i && rx_ready && !rd_i && !clr_i) |=> (err_overrun && $stable(rx_data)))
        else $error("overrun overwrote buffer"); // R6
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !(rx_ready || err_parity || err_frame || err_overrun || brk_det))
        else $error("flag survived clear"); // R9
    AST_BREAK_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && brk_i && !rx_ready && !clr_i) |=> (!rx_ready && brk_det))
        else $error("break loaded buffer"); // R7
endmodule

// File: rtl/async_rx.sv
// Top of the programmable asynchronous receiver: synchroniser, tick divider,
// frame walker and status holder.
// Assumes: format and divisor inputs change only while the line is idle.
module async_rx #(
    parameter int DIV_W      = 16,
    parameter int DATA_MAX   = 8,
    parameter int TICKS      = 8,
    parameter int START_TICK = 4,
    parameter int SYNC       = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sw_clr,
    input  logic                        rx_en,
    input  logic                        rx_irq_en,
    input  logic [DIV_W-1:0]            baud_div,
    input  logic [$clog2(DATA_MAX)-1:0] char_len,
    input  logic                        par_en,
    input  logic                        par_even,
    input  logic                        two_stop,
    input  logic                        rxd,
    input  logic                        buf_rd,
    output logic [DATA_MAX-1:0]         rx_data,
    output logic                        rx_ready,
    output logic                        err_parity,
    output logic                        err_frame,
    output logic                        err_overrun,
    output logic                        brk_det,
    output logic                        rx_irq
);
    logic                line_s;
    logic                run;
    logic                tick;
    logic                done;
    logic [DATA_MAX-1:0] fr_data;
    logic                fr_perr;
    logic                fr_ferr;
    logic                fr_brk;

    arx_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    arx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(baud_div), .tick_o(tick)
    );

    arx_deframer #(.DATA_MAX(DATA_MAX), .TICKS(TICKS), .START_TICK(START_TICK)) u_frame (
        .clk(clk), .rst_n(rst_n), .clr_i(sw_clr), .en_i(rx_en), .line_i(line_s),
        .tick_i(tick), .len_i(char_len), .pen_i(par_en), .peven_i(par_even),
        .two_i(two_stop), .run_o(run), .done_o(done), .data_o(fr_data),
        .perr_o(fr_perr), .ferr_o(fr_ferr), .brk_o(fr_brk)
    );

    arx_status #(.DATA_MAX(DATA_MAX)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr_i(sw_clr), .rd_i(buf_rd), .irq_en_i(rx_irq_en),
        .done_i(done), .data_i(fr_data), .perr_i(fr_perr), .ferr_i(fr_ferr), .brk_i(fr_brk),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun), .brk_det(brk_det), .rx_irq(rx_irq)
    );
endmodule

// File: tb/async_rx_tb.sv
`timescale 1ns/1ps
module async_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n, sw_clr, rx_en, rx_irq_en, par_en, par_even, two_stop, rxd, buf_rd;
    logic [15:0] baud_div;
    logic [2:0]  char_len;
    logic [7:0]  rx_data;
    logic        rx_ready, err_parity, err_frame, err_overrun, brk_det, rx_irq;

    int checks = 0;
    int fails  = 0;
    int bp     = 32;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    async_rx dut_i (
        .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .rx_en(rx_en), .rx_irq_en(rx_irq_en),
        .baud_div(baud_div), .char_len(char_len), .par_en(par_en), .par_even(par_even),
        .two_stop(two_stop), .rxd(rxd), .buf_rd(buf_rd), .rx_data(rx_data),
        .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .brk_det(brk_det), .rx_irq(rx_irq)
    );

    // {len, pen, peven, two, data, bad_par, bad_stop, exp_data, exp_perr, exp_ferr}
    localparam logic [25:0] VEC [8] = '{
        {3'd7, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
        {3'd4, 1'b1, 1'b1, 1'b0, 8'h3B, 1'b0, 1'b0, 8'h1B, 1'b0, 1'b0},
        {3'd0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0},
        {3'd7, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0},
        {3'd6, 1'b1, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1},
        {3'd3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {3'd7, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0},
        {3'd2, 1'b1, 1'b1, 1'b1, 8'h06, 1'b0, 1'b0, 8'h06, 1'b0, 1'b0}
    };

    function automatic logic [13:0] obs();
        return {rx_ready, rx_data, err_parity, err_frame, err_overrun, brk_det, rx_irq};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd();
        buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clr();
        sw_clr = 1'b1; @(negedge clk); sw_clr = 1'b0; @(negedge clk);
    endtask

    task automatic send(input int len, input logic pe, input logic pev, input logic two,
                        input logic [7:0] d, input logic bpar, input logic bstop);
        logic p = 1'b0;
        char_len = 3'(len); par_en = pe; par_even = pev; two_stop = two;
        hold(1'b0, bp);
        for (int i = 0; i <= len; i++) begin
            hold(d[i], bp);
            p = p ^ d[i];
        end
        if (pe) hold(p ^ ~pev ^ bpar, bp);
        if (two) hold(1'b1, bp);
        hold(~bstop, bp);
        hold(1'b1, 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_clr = 1'b0; rx_en = 1'b1; rx_irq_en = 1'b1; baud_div = 16'd3;
        char_len = 3'd7; par_en = 1'b0; par_even = 1'b0; two_stop = 1'b0; rxd = 1'b1; buf_rd = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 reset state", 32'(obs()), 32'h0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // Table walk: formats, parity and stop-bit cases (R2 R3 R4 R11)
        foreach (VEC[i]) begin
            send(int'(VEC[i][25:23]), VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12],
                 VEC[i][11], VEC[i][10]);
            chk("R2/R3/R4 table vector", 32'(obs()),
                32'({1'b1, VEC[i][9:2], VEC[i][1], VEC[i][0], 1'b0, 1'b0, 1'b1}));
            pulse_rd();
            pulse_clr();
        end

        // R8: read clears ready, keeps the character
        send(7, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0);
        chk("R8 ready before read", 32'(rx_ready), 32'h1);
        pulse_rd();
        chk("R8 read clears ready", 32'({rx_ready, rx_data}), 32'({1'b0, 8'hA5}));

        // R6: second character without a read is dropped
        send(7, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0);
        send(7, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0);
        chk("R6 overrun keeps first", 32'({rx_ready, rx_data, err_overrun}), 32'({1'b1, 8'h5A, 1'b1}));
        pulse_clr();

        // R7: line held low for a whole frame and more
        hold(1'b0, 11 * bp);
        hold(1'b1, 8);
        chk("R7 break flags", 32'(obs()), 32'({1'b0, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}));
        pulse_clr();
        chk("R9 clear drops every flag", 32'(obs()), 32'({1'b0, 8'h5A, 5'b0}));

        // R5: a short low pulse is not a start bit
        hold(1'b0, 8);
        hold(1'b1, 3 * bp);
        chk("R5 glitch ignored", 32'(obs()), 32'({1'b0, 8'h5A, 5'b0}));
        send(7, 1'b0, 1'b0, 1'b0, 8'hC6, 1'b0, 1'b0);
        chk("R5 frame after glitch", 32'({rx_ready, rx_data}), 32'({1'b1, 8'hC6}));
        pulse_rd();

        // R11: interrupt gated by its enable
        rx_irq_en = 1'b0;
        send(7, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0);
        chk("R11 irq masked", 32'({rx_ready, rx_irq}), 32'({1'b1, 1'b0}));
        rx_irq_en = 1'b1;
        @(negedge clk);
        chk("R11 irq enabled", 32'(rx_irq), 32'h1);
        pulse_rd();

        // R10: disabled receiver ignores the line
        rx_en = 1'b0;
        send(7, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        hold(1'b1, bp);
        chk("R10 disabled receiver", 32'(obs()), 32'({1'b0, 8'h81, 5'b0}));
        rx_en = 1'b1;

        // R9: clear mid-frame aborts it
        hold(1'b0, 3 * bp);
        pulse_clr();
        hold(1'b1, 12 * bp);
        chk("R9 abort mid-frame", 32'(rx_ready), 32'h0);

        // R12: slower divisor
        baud_div = 16'd7; bp = 64;
        repeat (20) @(negedge clk);
        send(7, 1'b1, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b0);
        chk("R12 divisor 7", 32'(obs()), 32'({1'b1, 8'hC3, 5'b00001}));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule